// File: doc/BRIEF.md
# Data-Strobe Serial Transmitter

This block turns link characters into a pair of serial lines, a data line and a strobe line. At every bit boundary the data line takes the next bit. The strobe line changes only when the data line does not, so the XOR of the two lines flips once per bit. The bit rate comes from a clock divider. Each bit lasts the divider value plus one system clock cycles. Before the link reaches the running state, a fixed start-up divider is used. Once the link is running, the divider input is used, and a new value on that input applies from the next bit boundary on.

A link controller enables the transmitter and requests flow-control tokens. An application hands over N-Chars, each a flag and a byte, with a valid/acknowledge handshake. A TimeCode request is a one-cycle pulse that is held internally until it is sent. The block sends an escape-prefixed NULL whenever it has nothing else to send. Each character carries a leading parity bit, which gives odd parity over the previous character's payload and the current flag.

Top module: `ds_tx`

## Requirements
- R1: While `tx_en` is low, `ds_d` and `ds_s` are low from the next clock edge on, and no acknowledge is issued. After reset both lines are low.
- R2: With `link_run` high, consecutive bit boundaries are `div_in`+1 clock cycles apart. A changed `div_in` applies from the next bit boundary without disabling the transmitter.
- R3: With `link_run` low, the bit period is `INIT_DIV`+1 cycles whatever `div_in` holds.
- R4: At each bit boundary exactly one of `ds_d` and `ds_s` changes, and `ds_d` carries the bit. Between boundaries both lines are stable.
- R5: The first bit of every character is a parity bit. That bit, XORed with the previous character's payload bits (zero before the first character after enable) and the current flag bit, equals 1.
- R6: A data character is parity, flag 0, then the 8 data bits with bit 0 first.
- R7: A control character is parity, flag 1, then a 2-bit code sent high bit first: FCT=00, EOP=01, EEP=10, ESC=11. An N-Char with `nc_flag` high is sent as EOP when `nc_byte[0]` is 0 and as EEP when it is 1.
- R8: With no request pending, the block sends NULL, which is ESC followed by FCT.
- R9: A `tc_req` pulse is held until it is sent, even across a period with `tx_en` low. It goes out as ESC followed by a data character whose bits [7:6] are `tc_ctrl` and bits [5:0] are `tc_time`. `tc_ack` pulses once, in the cycle before the ESC is loaded.
- R10: At a character boundary the block picks, in this order: the second half of an ESC pair in progress, then a held TimeCode, then `fct_req`, then a valid N-Char, then NULL.
- R11: `nc_ack` and `fct_ack` pulse for one cycle in the cycle before their character is loaded. At most one acknowledge is high in any cycle, and `nc_ack` is never high without `nc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmitter enable from the link controller |
| link_run | input | 1 | Link is running; selects `div_in` over the start-up divider |
| div_in | input | DIV_W | Bit period minus one, in clock cycles |
| tc_req | input | 1 | One-cycle TimeCode request |
| tc_ctrl | input | 2 | TimeCode control bits |
| tc_time | input | 6 | TimeCode counter value |
| fct_req | input | 1 | Request to send a flow-control token |
| nc_valid | input | 1 | N-Char offered |
| nc_flag | input | 1 | N-Char is an end marker |
| nc_byte | input | 8 | N-Char data byte, or end marker selector in bit 0 |
| fct_ack | output | 1 | FCT accepted |
| nc_ack | output | 1 | N-Char accepted |
| tc_ack | output | 1 | TimeCode accepted |
| ds_d | output | 1 | Serial data line |
| ds_s | output | 1 | Serial strobe line |

## Verification
The bench recovers bits from the lines only, by watching for flips of data XOR strobe, and measures the cycle gap between flips. A divider that misses by one cycle, or that ignores the start-up value, shows up as a wrong gap. A sweep of all 256 bytes at the fastest rate catches any bit reordering or framing slip. Parity is rechecked on every character, so an off-by-one in the carried payload parity or a parity that is not reset on enable is caught. Priority is tested by placing a TimeCode, an FCT request and an N-Char together while disabled, then enabling: a wrong ordering, a TimeCode lost during the disabled period, or a NULL split by another character gives a character sequence that does not match.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;

  localparam int CHAR_W = 10;   // parity + flag + 8 data bits
  localparam int LEN_W  = 4;

  typedef logic [1:0] ctl_code_t;
  localparam ctl_code_t C_FCT = 2'b00;
  localparam ctl_code_t C_EOP = 2'b01;
  localparam ctl_code_t C_EEP = 2'b10;
  localparam ctl_code_t C_ESC = 2'b11;

  // One character ready for the shifter; bits[0] leaves first.
  typedef struct packed {
    logic [CHAR_W-1:0] bits;
    logic [LEN_W-1:0]  len;
    logic              acc;   // payload parity for the next character
  } char_t;

  typedef enum logic [1:0] {TAIL_NONE, TAIL_FCT, TAIL_TIME} tail_e;

  typedef enum logic [2:0] {
    PK_TAIL_FCT, PK_TAIL_TIME, PK_TIME, PK_FCT, PK_NCHAR, PK_NULL
  } pick_e;

  // Odd parity: p ^ acc_prev ^ flag == 1.
  function automatic logic lead_parity(logic acc_prev, logic flag);
    return ~(acc_prev ^ flag);
  endfunction

  function automatic char_t make_ctrl(ctl_code_t c, logic acc_prev);
    char_t r;
    r.bits = {{(CHAR_W-4){1'b0}}, c[0], c[1], 1'b1, lead_parity(acc_prev, 1'b1)};
    r.len  = LEN_W'(4);
    r.acc  = ^c;
    return r;
  endfunction

  function automatic char_t make_data(logic [7:0] b, logic acc_prev);
    char_t r;
    r.bits = {b, 1'b0, lead_parity(acc_prev, 1'b0)};
    r.len  = LEN_W'(CHAR_W);
    r.acc  = ^b;
    return r;
  endfunction

endpackage

// File: rtl/ds_tx_baud.sv
module ds_tx_baud #(
  parameter int DIV_W    = 8,
  parameter int INIT_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic [DIV_W-1:0] div_in,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_eff;

  // Compare with >= so a smaller divider applies at once.
  always_comb begin
    div_eff = run ? div_in : DIV_W'(INIT_DIV);
    tick    = en && (cnt >= div_eff);
  end

  always_ff @(posedge clk) begin
    if (rst || !en)  cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R2: after a boundary another one follows at once only for divider zero
  a_r2_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    tick |=> (!tick || div_eff == '0));

  // R1: no boundary while disabled
  a_r1_no_tick_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0));

endmodule

// File: rtl/ds_tx_shift.sv
module ds_tx_shift
  import ds_tx_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  en,
  input  logic  tick,
  input  char_t char_in,
  output logic  load,
  output logic  ds_d,
  output logic  ds_s
);

  logic [CHAR_W-1:0] sh;
  logic [LEN_W-1:0]  left;
  logic              nxt_bit;

  always_comb begin
    load    = tick && (left == '0);
    nxt_bit = load ? char_in.bits[0] : sh[0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sh   <= '0;
      left <= '0;
      ds_d <= 1'b0;
      ds_s <= 1'b0;
    end else if (tick) begin
      ds_d <= nxt_bit;
      ds_s <= ds_s ^ (nxt_bit ~^ ds_d);
      if (load) begin
        sh   <= char_in.bits >> 1;
        left <= char_in.len - 1'b1;
      end else begin
        sh   <= sh >> 1;
        left <= left - 1'b1;
      end
    end
  end

  // R1: lines low while disabled
  a_r1_lines_low: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!ds_d && !ds_s));

  // R4: data XOR strobe flips at each boundary
  a_r4_xor_flips: assert property (@(posedge clk) disable iff (rst)
    (en && tick) |=> (!en || ((ds_d ^ ds_s) != $past(ds_d ^ ds_s))));

  // R4: lines hold between boundaries
  a_r4_lines_hold: assert property (@(posedge clk) disable iff (rst)
    (en && !tick) |=> (!en || ($stable(ds_d) && $stable(ds_s))));

endmodule

// File: rtl/ds_tx_pick.sv
module ds_tx_pick
  import ds_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic       load,
  input  logic       tc_req,
  input  logic [1:0] tc_ctrl,
  input  logic [5:0] tc_time,
  input  logic       fct_req,
  input  logic       nc_valid,
  input  logic       nc_flag,
  input  logic [7:0] nc_byte,
  output char_t      char_out,
  output logic       fct_ack,
  output logic       nc_ack,
  output logic       tc_ack
);

  logic       tc_pend;
  logic [7:0] tc_byte;
  tail_e      tail;
  logic [7:0] tail_byte;
  logic       acc;
  pick_e      sel;

  always_comb begin
    if      (tail == TAIL_FCT)  sel = PK_TAIL_FCT;
    else if (tail == TAIL_TIME) sel = PK_TAIL_TIME;
    else if (tc_pend)           sel = PK_TIME;
    else if (fct_req)           sel = PK_FCT;
    else if (nc_valid)          sel = PK_NCHAR;
    else                        sel = PK_NULL;

    case (sel)
      PK_TAIL_FCT, PK_FCT: char_out = make_ctrl(C_FCT, acc);
      PK_TAIL_TIME:        char_out = make_data(tail_byte, acc);
      PK_TIME, PK_NULL:    char_out = make_ctrl(C_ESC, acc);
      default:             char_out = nc_flag
                                    ? make_ctrl(nc_byte[0] ? C_EEP : C_EOP, acc)
                                    : make_data(nc_byte, acc);
    endcase

    tc_ack  = load && (sel == PK_TIME);
    fct_ack = load && (sel == PK_FCT);
    nc_ack  = load && (sel == PK_NCHAR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_pend   <= 1'b0;
      tc_byte   <= '0;
      tail      <= TAIL_NONE;
      tail_byte <= '0;
      acc       <= 1'b0;
    end else begin
      if (!en) begin
        tail <= TAIL_NONE;
        acc  <= 1'b0;
      end else if (load) begin
        acc <= char_out.acc;
        case (sel)
          PK_TIME: begin
            tail      <= TAIL_TIME;
            tail_byte <= tc_byte;
          end
          PK_NULL: tail <= TAIL_FCT;
          default: tail <= TAIL_NONE;
        endcase
      end
      // TimeCode request is held across disable; latest request wins
      if (tc_req) begin
        tc_pend <= 1'b1;
        tc_byte <= {tc_ctrl, tc_time};
      end else if (tc_ack) begin
        tc_pend <= 1'b0;
      end
    end
  end

  // R11: at most one acknowledge per cycle
  a_r11_one_ack: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tc_ack, fct_ack, nc_ack}));

  // R11: N-Char acknowledge only for an offered character
  a_r11_ack_valid: assert property (@(posedge clk) disable iff (rst)
    nc_ack |-> nc_valid);

  // R9: a held TimeCode stays held until acknowledged
  a_r9_tc_held: assert property (@(posedge clk) disable iff (rst)
    (tc_pend && !tc_ack) |=> tc_pend);

  // R10: the second half of an ESC pair is never displaced
  a_r10_tail_first: assert property (@(posedge clk) disable iff (rst)
    (load && tail != TAIL_NONE) |-> !(tc_ack || fct_ack || nc_ack));

endmodule

// File: rtl/ds_tx.sv
module ds_tx
  import ds_tx_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int INIT_DIV = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             link_run,
  input  logic [DIV_W-1:0] div_in,
  input  logic             tc_req,
  input  logic [1:0]       tc_ctrl,
  input  logic [5:0]       tc_time,
  input  logic             fct_req,
  input  logic             nc_valid,
  input  logic             nc_flag,
  input  logic [7:0]       nc_byte,
  output logic             fct_ack,
  output logic             nc_ack,
  output logic             tc_ack,
  output logic             ds_d,
  output logic             ds_s
);

  logic  bit_tick;
  logic  char_load;
  char_t next_char;

  ds_tx_baud #(.DIV_W(DIV_W), .INIT_DIV(INIT_DIV)) u_baud (
    .clk    (clk),
    .rst    (rst),
    .en     (tx_en),
    .run    (link_run),
    .div_in (div_in),
    .tick   (bit_tick)
  );

  ds_tx_pick u_pick (
    .clk      (clk),
    .rst      (rst),
    .en       (tx_en),
    .load     (char_load),
    .tc_req   (tc_req),
    .tc_ctrl  (tc_ctrl),
    .tc_time  (tc_time),
    .fct_req  (fct_req),
    .nc_valid (nc_valid),
    .nc_flag  (nc_flag),
    .nc_byte  (nc_byte),
    .char_out (next_char),
    .fct_ack  (fct_ack),
    .nc_ack   (nc_ack),
    .tc_ack   (tc_ack)
  );

  ds_tx_shift u_shift (
    .clk     (clk),
    .rst     (rst),
    .en      (tx_en),
    .tick    (bit_tick),
    .char_in (next_char),
    .load    (char_load),
    .ds_d    (ds_d),
    .ds_s    (ds_s)
  );

  // R11: acknowledges only at a character boundary
  a_r11_ack_on_load: assert property (@(posedge clk) disable iff (rst)
    (tc_ack || fct_ack || nc_ack) |-> char_load);

endmodule

// File: tb/ds_tx_tb.sv
module ds_tx_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0, link_run = 1'b0;
  logic [7:0] div_in = 8'd7;
  logic       tc_req = 1'b0, fct_req = 1'b0;
  logic [1:0] tc_ctrl = '0;
  logic [5:0] tc_time = '0;
  logic       nc_valid = 1'b0, nc_flag = 1'b0;
  logic [7:0] nc_byte = '0;
  logic       fct_ack, nc_ack, tc_ack, ds_d, ds_s;

  ds_tx #(.DIV_W(8), .INIT_DIV(4)) u_dut (
    .clk(clk), .rst(rst), .tx_en(tx_en), .link_run(link_run), .div_in(div_in),
    .tc_req(tc_req), .tc_ctrl(tc_ctrl), .tc_time(tc_time), .fct_req(fct_req),
    .nc_valid(nc_valid), .nc_flag(nc_flag), .nc_byte(nc_byte),
    .fct_ack(fct_ack), .nc_ack(nc_ack), .tc_ack(tc_ack), .ds_d(ds_d), .ds_s(ds_s)
  );

  always #10 clk = ~clk;   // 50 MHz

  int errors = 0, checks = 0, cyc = 0;

  // line decoder state
  logic       log_kind [0:511];
  logic [7:0] log_val  [0:511];
  int nlog = 0, par_bad = 0, gap_bad = 0, gaps_seen = 0, exp_gap = 0;
  int both_bad = 0, nack_cnt = 0, tack_cnt = 0, last_cyc = 0;
  logic px = 0, pd = 0, ps = 0, pbit = 0, flag = 0, acc = 0, have_last = 0;
  int st = 0, nbits = 0, bcnt = 0;
  logic [7:0] val = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (nc_ack) nack_cnt++;
    if (tc_ack) tack_cnt++;
    if (!tx_en) begin
      px = 0; st = 0; acc = 0; have_last = 0;
    end else begin
      if ((ds_d != pd) && (ds_s != ps)) both_bad++;
      if ((ds_d ^ ds_s) != px) begin
        px = ds_d ^ ds_s;
        if (have_last && exp_gap != 0) begin
          gaps_seen++;
          if (cyc - last_cyc != exp_gap) gap_bad++;
        end
        last_cyc = cyc; have_last = 1;
        case (st)
          0: begin pbit = ds_d; st = 1; end
          1: begin
            flag = ds_d;
            if ((pbit ^ acc ^ flag) != 1'b1) par_bad++;
            nbits = flag ? 2 : 8; bcnt = 0; val = 0; st = 2;
          end
          default: begin
            if (flag) val = {val[6:0], ds_d};
            else      val[bcnt] = ds_d;
            bcnt++;
            if (bcnt == nbits) begin
              if (nlog < 512) begin
                log_kind[nlog] = flag; log_val[nlog] = val; nlog++;
              end
              acc = ^val; st = 0;
            end
          end
        endcase
      end
    end
    pd = ds_d; ps = ds_s;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); #2; end
  endtask

  task automatic send_nc(input logic f, input logic [7:0] b);
    int guard;
    nc_flag = f; nc_byte = b; nc_valid = 1'b1; #1;
    guard = 0;
    while (!nc_ack && guard < 1000) begin @(posedge clk); #2; guard++; end
    @(posedge clk); #2;
    nc_valid = 1'b0;
  endtask

  task automatic expect_char(input int idx, input logic k, input int v, input string req);
    chk(idx < nlog, req, nlog, idx + 1);
    if (idx < nlog) begin
      chk(log_kind[idx] == k, req, int'(log_kind[idx]), int'(k));
      chk(int'(log_val[idx]) == v, req, int'(log_val[idx]), v);
    end
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(3);
    // R1: reset state
    chk(!ds_d && !ds_s, "R1 lines after reset", {ds_d, ds_s}, 0);
    chk(!fct_ack && !nc_ack && !tc_ack, "R1 acks idle", {fct_ack, nc_ack, tc_ack}, 0);

    // R3 / R8: start-up rate, NULL filler, div_in ignored
    nlog = 0; gap_bad = 0; gaps_seen = 0; exp_gap = 5;
    tx_en = 1'b1;
    step(400);
    chk(gap_bad == 0 && gaps_seen > 40, "R3 start-up gap", gap_bad, 0);
    chk(nlog >= 12, "R8 NULL count", nlog, 12);
    for (int i = 0; i < 12; i++)
      expect_char(i, 1'b1, (i % 2 == 0) ? 3 : 0, "R8 NULL pattern");

    // R1: disable drops lines
    tx_en = 1'b0;
    step(1);
    chk(!ds_d && !ds_s, "R1 lines when disabled", {ds_d, ds_s}, 0);
    step(5);
    chk(!ds_d && !ds_s && !fct_ack, "R1 stays low", {ds_d, ds_s}, 0);

    // R6 / R7 / R11: all bytes at fastest rate, then end markers
    link_run = 1'b1; div_in = 8'd0; exp_gap = 1;
    nlog = 0; gap_bad = 0; gaps_seen = 0; nack_cnt = 0;
    tx_en = 1'b1;
    for (int b = 0; b < 256; b++) send_nc(1'b0, 8'(b));
    send_nc(1'b1, 8'h00);
    send_nc(1'b1, 8'h01);
    send_nc(1'b1, 8'hFE);   // R7: bit 0 low selects EOP
    step(40);
    for (int b = 0; b < 256; b++) expect_char(b, 1'b0, b, "R6 data byte");
    expect_char(256, 1'b1, 1, "R7 EOP");
    expect_char(257, 1'b1, 2, "R7 EEP");
    expect_char(258, 1'b1, 1, "R7 EOP from bit0");
    expect_char(259, 1'b1, 3, "R8 NULL after data");
    chk(gap_bad == 0, "R2 divider zero gap", gap_bad, 0);
    chk(nack_cnt == 259, "R11 nc_ack count", nack_cnt, 259);

    // R9 / R10: TimeCode latched while disabled, priority order
    tx_en = 1'b0; div_in = 8'd1; exp_gap = 2;
    step(2);
    tc_ctrl = 2'b10; tc_time = 6'h2B; tc_req = 1'b1;
    fct_req = 1'b1; nc_flag = 1'b0; nc_byte = 8'h5A; nc_valid = 1'b1;
    step(1);
    tc_req = 1'b0;
    step(3);
    nlog = 0; gap_bad = 0; tack_cnt = 0;
    tx_en = 1'b1;
    begin
      bit drop_f = 0, drop_n = 0;
      for (int i = 0; i < 200; i++) begin
        step(1);
        if (drop_f) fct_req = 1'b0;
        if (drop_n) nc_valid = 1'b0;
        #1;
        if (fct_ack) drop_f = 1;
        if (nc_ack)  drop_n = 1;
      end
    end
    expect_char(0, 1'b1, 3, "R9 ESC first");
    expect_char(1, 1'b0, 8'hAB, "R9 TimeCode byte");
    expect_char(2, 1'b1, 0, "R10 FCT before N-Char");
    expect_char(3, 1'b0, 8'h5A, "R10 N-Char after FCT");
    expect_char(4, 1'b1, 3, "R10 NULL ESC");
    expect_char(5, 1'b1, 0, "R10 NULL FCT");
    chk(tack_cnt == 1, "R9 one tc_ack", tack_cnt, 1);
    chk(gap_bad == 0, "R2 divider one gap", gap_bad, 0);

    // R2: divider changes on the fly
    exp_gap = 0; div_in = 8'd3;
    step(20);
    gap_bad = 0; gaps_seen = 0; exp_gap = 4;
    step(120);
    chk(gap_bad == 0 && gaps_seen >= 20, "R2 divider three", gap_bad, 0);
    exp_gap = 0; div_in = 8'd2;
    step(8);
    gap_bad = 0; gaps_seen = 0; exp_gap = 3;
    step(90);
    chk(gap_bad == 0 && gaps_seen >= 20, "R2 divider two", gap_bad, 0);

    // R3: dropping out of run returns to the start-up rate
    exp_gap = 0; link_run = 1'b0;
    step(12);
    gap_bad = 0; gaps_seen = 0; exp_gap = 5;
    step(150);
    chk(gap_bad == 0 && gaps_seen >= 20, "R3 back to start-up", gap_bad, 0);

    chk(par_bad == 0, "R5 parity", par_bad, 0);
    chk(both_bad == 0, "R4 one line per bit", both_bad, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule